// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous SRAM whose reads and writes can follow each other on every clock without a turnaround gap. A read returns registered data one recognized clock after its address cycle. A write takes its address at one edge and its data two recognized edges later. Because both pipelines have the same length, the data bus carries one word per clock in either direction, whatever the mix of accesses. The common I/O bus is split into a data input, a registered data output and an output-enable that an outer pad ring turns into a tri-state driver.

An access begins with a load cycle, when the three chip selects agree and the load control is low. An advance cycle replays the type of the last loaded access at the address now on the address port. An external burst sequencer supplies that address. A low clock enable is needed for any edge to count. When it is high, the whole pipeline freezes, and so do a pending write and the read data on the bus. Each word holds four byte lanes. Each lane is eight data bits plus one parity bit, and each lane has its own active-low write select. A read that follows a write to the same address on the next cycle sees the new lanes merged in.

There is no valid/ready handshake. The bus runs at a fixed latency, and the clock enable is the only way to apply back-pressure: holding it high stalls every stage at once.

Top module: `lwp_sram`

## Requirements
- R1: An edge is recognized only when `cke_n` is 0. At a recognized edge with `ld_n` = 0, an access is loaded only if `cs1_n` = 0, `cs2` = 1 and `cs3_n` = 0; it is a read when `we_n` = 1 and a write when `we_n` = 0. Any other chip-select pattern loads a deselect.
- R2: A read loaded at recognized edge N drives `dq_out` = stored word after recognized edge N+1, and `dq_oe` = 1 then if `oe_n` = 0.
- R3: A write loaded at recognized edge N gives `dq_oe` = 0 after edge N+1. It stores `dq_in` as sampled at recognized edge N+2.
- R4: Each data word has four lanes. Lane k is data bits [8k+7:8k] plus parity bit 32+k. A write stores lane k only when `bw_n[k]` = 0, using the `bw_n` sampled at its address edge. Lanes that are not selected keep their stored value.
- R5: At an edge with `cke_n` = 1, all state holds. `dq_out` and `dq_oe` do not change, and `dq_in` is not sampled, so a pending write waits for the next recognized edge.
- R6: After a deselect is loaded at recognized edge N, `dq_oe` = 0 following edge N+1.
- R7: `dq_oe` = 0 regardless of `oe_n` in three cases: in the data cycle of a write, in the first cycle after leaving the deselected state, and while deselected.
- R8: While `rst_n` = 0 and after it is released, the block is deselected and `dq_oe` = 0 until a read completes.
- R9: A read loaded one recognized edge after a write to the same address returns the stored word with that write's selected lanes taken from its data.
- R10: At a recognized edge with `ld_n` = 1, the chip selects and `we_n` are ignored. The access type of the last load is repeated at the current `addr` with the current `bw_n`. After a deselect load, an advance stays deselected.
- R11: `oe_n` acts asynchronously: while a read is driving, `dq_oe` follows `!oe_n` without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset (deselected state) |
| cke_n | input | 1 | Clock enable, active low; high freezes the pipeline |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | 0 = load new access, 1 = advance (repeat last type) |
| we_n | input | 1 | 0 = write, 1 = read, sampled on load |
| bw_n | input | LANES | Per-lane write selects, active low |
| addr | input | AW | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_in | input | DW | Write data, sampled two recognized edges after the address |
| dq_out | output | DW | Registered read data |
| dq_oe | output | 1 | High when the block drives the bus |

## Verification
The bench builds the block with a 4-bit address, which gives 16 words, and keeps the default four lanes of eight bits. The whole array is then written in 16 back-to-back cycles. Random traffic in that small space often lands a read on an address whose write is still pending, so the forwarding path and write-after-write on one word are hit many times. The reference model runs at every clock, so random stalls also land between the address cycle and the data cycle of a write.

// File: rtl/lwp_sram_pkg.sv
package lwp_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/lwp_cmd_stage.sv
// Address-cycle register: decodes selects/load/write-enable into an access
// type and remembers the type of the last load for advance cycles.
module lwp_cmd_stage
  import lwp_sram_pkg::*;
#(
  parameter int AW    = 10,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_bw_n
);
  logic sel;
  op_e  burst_op;
  op_e  nxt_op;

  always_comb begin
    sel = ~cs1_n & cs2 & ~cs3_n;
    if (!ld_n) nxt_op = sel ? (we_n ? OP_RD : OP_WR) : OP_IDLE;
    else       nxt_op = burst_op;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      burst_op <= OP_IDLE;
      s1_addr  <= '0;
      s1_bw_n  <= '1;
    end else if (!cke_n) begin
      s1_op   <= nxt_op;
      s1_addr <= addr;
      s1_bw_n <= bw_n;
      if (!ld_n) burst_op <= nxt_op;
    end
  end
endmodule

// File: rtl/lwp_lane_merge.sv
// Per-lane select between a stored word and incoming data. Lane k is data
// bits [k*LANE_BITS +: LANE_BITS] plus parity bit LANES*LANE_BITS+k.
module lwp_lane_merge #(
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  localparam int DW       = LANES * (LANE_BITS + 1)
) (
  input  logic [DW-1:0]    old_w,
  input  logic [DW-1:0]    new_w,
  input  logic [LANES-1:0] keep_n,
  output logic [DW-1:0]    out_w
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign out_w[k*LANE_BITS +: LANE_BITS] =
      keep_n[k] ? old_w[k*LANE_BITS +: LANE_BITS] : new_w[k*LANE_BITS +: LANE_BITS];
    assign out_w[LANES*LANE_BITS + k] =
      keep_n[k] ? old_w[LANES*LANE_BITS + k] : new_w[LANES*LANE_BITS + k];
  end
endmodule

// File: rtl/lwp_store.sv
// Storage array: one synchronous write port, two combinational read ports
// (one for the read access, one for the write merge).
module lwp_store #(
  parameter int AW = 10,
  parameter int DW = 36,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/lwp_sram.sv
module lwp_sram
  import lwp_sram_pkg::*;
#(
  parameter int AW        = 10,
  parameter int LANES     = 4,
  parameter int LANE_BITS = 8,
  localparam int DW       = LANES * (LANE_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             ld_n,
  input  logic             we_n,
  input  logic [LANES-1:0] bw_n,
  input  logic [AW-1:0]    addr,
  input  logic             oe_n,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  op_e              s1_op;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_bw_n;

  logic             s2_wr;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_bw_n;

  logic [DW-1:0]    rd_raw;
  logic [DW-1:0]    wr_old;
  logic [DW-1:0]    wr_merged;
  logic [DW-1:0]    rd_word;
  logic             fwd_hit;
  logic             commit;

  logic [DW-1:0]    out_q;
  logic             drv_q;

  lwp_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_n   (cke_n),
    .cs1_n   (cs1_n),
    .cs2     (cs2),
    .cs3_n   (cs3_n),
    .ld_n    (ld_n),
    .we_n    (we_n),
    .bw_n    (bw_n),
    .addr    (addr),
    .s1_op   (s1_op),
    .s1_addr (s1_addr),
    .s1_bw_n (s1_bw_n)
  );

  // Data-cycle stage: a write waits here for its bus data.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_bw_n <= '1;
    end else if (!cke_n) begin
      s2_wr   <= (s1_op == OP_WR);
      s2_addr <= s1_addr;
      s2_bw_n <= s1_bw_n;
    end
  end

  assign commit = ~cke_n & s2_wr;

  lwp_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .we      (commit),
    .waddr   (s2_addr),
    .wdata   (wr_merged),
    .raddr_a (s1_addr),
    .rdata_a (rd_raw),
    .raddr_b (s2_addr),
    .rdata_b (wr_old)
  );

  lwp_lane_merge #(.LANES(LANES), .LANE_BITS(LANE_BITS)) u_merge (
    .old_w  (wr_old),
    .new_w  (dq_in),
    .keep_n (s2_bw_n),
    .out_w  (wr_merged)
  );

  // The only write not yet in the array when a read samples it is the one
  // committing on this very edge; its merged word replaces the raw read.
  assign fwd_hit = s2_wr && (s2_addr == s1_addr);
  assign rd_word = fwd_hit ? wr_merged : rd_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      drv_q <= 1'b0;
    end else if (!cke_n) begin
      drv_q <= (s1_op == OP_RD);
      if (s1_op == OP_RD) out_q <= rd_word;
    end
  end

  assign dq_out = out_q;
  assign dq_oe  = drv_q & ~oe_n;
endmodule

// File: rtl/lwp_sram_chk.sv
module lwp_sram_chk
  import lwp_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cke_n,
  input logic          cs1_n,
  input logic          cs2,
  input logic          cs3_n,
  input logic          ld_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input op_e           s1_op
);
  // R1
  desel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !(!cs1_n && cs2 && !cs3_n)) |=> (s1_op == OP_IDLE));

  // R1
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !ld_n && !cs1_n && cs2 && !cs3_n) |=> (s1_op != OP_IDLE));

  // R2
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_op == OP_RD) |=> (dq_oe == !oe_n));

  // R3
  wr_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_op == OP_WR) |=> !dq_oe);

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> $stable(dq_out));

  // R6
  desel_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && s1_op == OP_IDLE) |=> !dq_oe);

  // R8
  reset_float_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !dq_oe);

  // R10
  advance_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && ld_n) |=> (s1_op == $past(s1_op)));
endmodule

bind lwp_sram lwp_sram_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cke_n  (cke_n),
  .cs1_n  (cs1_n),
  .cs2    (cs2),
  .cs3_n  (cs3_n),
  .ld_n   (ld_n),
  .oe_n   (oe_n),
  .dq_out (dq_out),
  .dq_oe  (dq_oe),
  .s1_op  (s1_op)
);

// File: tb/lwp_sram_test.sv
module lwp_sram_test;
  localparam int AW = 4;
  localparam int LANES = 4;
  localparam int LB = 8;
  localparam int DW = LANES * (LB + 1);
  localparam int WORDS = 1 << AW;

  typedef struct {
    int            kind;   // 0 idle, 1 read, 2 write
    logic [AW-1:0] a;
    logic [3:0]    bw;
    logic [DW-1:0] d;
  } ent_t;

  logic clk = 0, rst_n = 0;
  logic cke_n = 0, cs1_n = 1, cs2 = 0, cs3_n = 1, ld_n = 0, we_n = 1, oe_n = 0;
  logic [3:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [DW-1:0] ref_mem [WORDS];
  ent_t hist[$];
  int   last_kind = 0;
  bit   exp_drv = 0;
  logic [DW-1:0] exp_data = '0;

  always #5 clk = ~clk;

  lwp_sram #(.AW(AW), .LANES(LANES), .LANE_BITS(LB)) uut (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .ld_n(ld_n), .we_n(we_n), .bw_n(bw_n), .addr(addr),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  function automatic logic [DW-1:0] rnd_word();
    logic [63:0] r;
    r = {$urandom(), $urandom()};
    return r[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] lane_write(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] m);
    logic [DW-1:0] res = old;
    for (int k = 0; k < LANES; k++) begin
      if (!m[k]) begin
        for (int b = 0; b < LB; b++) res[k*LB+b] = nw[k*LB+b];
        res[LANES*LB+k] = nw[LANES*LB+k];
      end
    end
    return res;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, advance the reference model at the edge,
  // compare at the following negedge.
  task automatic step(input logic c_n, input logic s1n, input logic s2, input logic s3n,
                      input logic ld, input logic we, input logic [3:0] bw,
                      input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic oe, input string tag);
    ent_t e;
    int kind;
    bit sel;
    cke_n = c_n; cs1_n = s1n; cs2 = s2; cs3_n = s3n; ld_n = ld; we_n = we;
    bw_n = bw; addr = a; oe_n = oe;
    if (!c_n && hist.size() >= 2 && hist[hist.size()-2].kind == 2)
      dq_in = hist[hist.size()-2].d;
    else
      dq_in = rnd_word();
    @(posedge clk);
    if (!c_n) begin
      sel = !s1n && s2 && !s3n;
      if (!ld) begin
        kind = sel ? (we ? 1 : 2) : 0;
        last_kind = kind;
      end else kind = last_kind;
      if (hist.size() >= 2 && hist[hist.size()-2].kind == 2)
        ref_mem[hist[hist.size()-2].a] =
          lane_write(ref_mem[hist[hist.size()-2].a], dq_in, hist[hist.size()-2].bw);
      if (hist.size() >= 1 && hist[hist.size()-1].kind == 1) begin
        exp_drv = 1;
        exp_data = ref_mem[hist[hist.size()-1].a];
      end else exp_drv = 0;
      e.kind = kind; e.a = a; e.bw = bw; e.d = wd;
      hist.push_back(e);
      if (hist.size() > 3) void'(hist.pop_front());
    end
    @(negedge clk);
    check(dq_oe == (exp_drv && !oe), tag, {dq_oe, dq_out}, {exp_drv && !oe, exp_data});
    if (exp_drv && !oe)
      check(dq_out == exp_data, tag, {dq_oe, dq_out}, {1'b1, exp_data});
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(0, 0, 1, 0, 0, 1, 4'hF, a, '0, 0, tag);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] bw, input string tag);
    step(0, 0, 1, 0, 0, 0, bw, a, d, 0, tag);
  endtask
  task automatic desel(input string tag);
    step(0, 1, 1, 0, 0, 1, 4'hF, '0, '0, 0, tag);
  endtask
  task automatic stall(input string tag);
    step(1, 0, 1, 0, 0, 1, 4'hF, '0, '0, 0, tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset holds the bus released even with oe_n low
    check(dq_oe == 0, "R8", {dq_oe, dq_out}, '0);
    rst_n = 1;
    desel("R8");
    desel("R8");

    // R3: fill the array back to back
    for (int i = 0; i < WORDS; i++) wr(i[AW-1:0], rnd_word(), 4'h0, "R3");
    desel("R6"); desel("R6");

    // R2: streaming reads
    for (int i = 0; i < WORDS; i++) rd(i[AW-1:0], "R2");
    // R6 and R7: deselect releases after next edge; read after deselect floats first
    desel("R6"); desel("R7"); rd(4'd3, "R7"); rd(4'd4, "R2"); desel("R6");

    // R3 / R2: alternating write/read with no gap
    for (int i = 0; i < 8; i++) begin
      wr(i[AW-1:0], rnd_word(), 4'h0, "R3");
      rd(4'(i + 8), "R2");
    end
    desel("R6"); desel("R6");

    // R4: partial lane writes then read back
    wr(4'd5, rnd_word(), 4'b1010, "R4");
    wr(4'd6, rnd_word(), 4'b0111, "R4");
    wr(4'd7, rnd_word(), 4'b1111, "R4");
    desel("R4"); rd(4'd5, "R4"); rd(4'd6, "R4"); rd(4'd7, "R4"); desel("R4"); desel("R4");

    // R9: read right behind a write to the same word, full and partial
    wr(4'd9, rnd_word(), 4'h0, "R9"); rd(4'd9, "R9");
    wr(4'd9, rnd_word(), 4'b1100, "R9"); rd(4'd9, "R9"); rd(4'd9, "R9");
    desel("R9"); desel("R9");

    // R5: stall between write address and data, and while read data is out
    wr(4'd2, rnd_word(), 4'h0, "R5");
    stall("R5"); stall("R5"); stall("R5");
    rd(4'd2, "R5"); stall("R5"); stall("R5"); rd(4'd2, "R5");
    stall("R5"); desel("R5"); desel("R5");

    // R1: each single select disabled loads a deselect
    step(0, 1, 1, 0, 0, 1, 4'hF, 4'd1, '0, 0, "R1"); desel("R1");
    step(0, 0, 0, 0, 0, 1, 4'hF, 4'd1, '0, 0, "R1"); desel("R1");
    step(0, 0, 1, 1, 0, 1, 4'hF, 4'd1, '0, 0, "R1"); desel("R1");
    rd(4'd1, "R1"); desel("R1");

    // R10: advance repeats read type with selects off and we_n low
    rd(4'd10, "R10");
    step(0, 1, 0, 1, 1, 0, 4'hF, 4'd11, '0, 0, "R10");
    step(0, 1, 0, 1, 1, 0, 4'hF, 4'd12, '0, 0, "R10");
    // advance after a write load stays a write
    wr(4'd13, rnd_word(), 4'h0, "R10");
    step(0, 1, 0, 1, 1, 1, 4'b0101, 4'd14, rnd_word(), 0, "R10");
    desel("R10"); rd(4'd13, "R10"); rd(4'd14, "R10");
    // advance after a deselect stays deselected
    desel("R10");
    step(0, 0, 1, 0, 1, 1, 4'hF, 4'd3, '0, 0, "R10");
    step(0, 0, 1, 0, 1, 1, 4'hF, 4'd3, '0, 0, "R10");

    // R11: output enable acts without a clock; R7: ignored in write data cycle
    rd(4'd4, "R11"); desel("R11");
    oe_n = 1; #1;
    check(dq_oe == 0, "R11", {dq_oe, dq_out}, '0);
    oe_n = 0; #1;
    check(dq_oe == 1, "R11", {dq_oe, dq_out}, {1'b1, exp_data});
    wr(4'd4, rnd_word(), 4'h0, "R7"); desel("R7");
    check(dq_oe == 0, "R7", {dq_oe, dq_out}, '0);
    desel("R7");

    // Mixed random traffic, every requirement in play
    for (int i = 0; i < 1500; i++) begin
      logic [31:0] r;
      r = $urandom();
      step(r[3:0] == 0, r[4] & r[5] & r[6], !(r[7] & r[8] & r[9]), r[10] & r[11] & r[12],
           r[13] & r[14], r[15], r[19:16], r[23:20], rnd_word(), r[27:24] == 0, "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule